// File: doc/BRIEF.md
# SMBus Host Register-File Emulator

This block stands in for the byte-wide register window of a legacy SMBus host controller sitting on a simple I/O bus. It does not drive any SMBus wires. Instead, it answers register reads and writes the way a host driver expects a real controller to answer them. It also turns the driver's access pattern into single-cycle event pulses for a separate transaction tracker.

The window holds the following registers:

- status;
- control with a protocol field;
- command;
- slave address;
- two data bytes;
- a block-data port backed by a 32-byte buffer;
- a packet-error-code byte;
- an auxiliary status byte and an auxiliary control byte.

Status reads have side effects:

- A read while idle acquires the in-use semaphore.
- Every read sets the semaphore.
- After a start, a fixed number of polls report busy before the done flag appears.

Top module: `smbh_host_emu`

## Requirements
- R1: The register offset is the bus address modulo the window size (16). Offsets 3 (command), 4 (slave address), 5 (data0), 6 (data1), 8 (error-code byte), 12 (aux status) and 13 (aux control) read back the last byte written. Any other offset except 0, 2 and 7 reads 0x00, and writes to it are ignored.
- R2: A control write (offset 2) stores the byte. A control read returns it with bit 6 cleared. Writing bit 6 pulses `ev_start`, and during that pulse `ev_proto` shows write-data bits [4:2] (0 at all other times). Writing bit 1 pulses `ev_abort`.
- R3: The first status read (offset 0) while idle returns 0x00 and pulses `ev_acquire`.
- R4: Each status read returns the current value and then sets bit 6. A read outside the idle state returns bit 6 = 1.
- R5: A status write clears each bit written as 1. Bit 6 pulses `ev_release` and returns the host to idle, except during a started transaction. Bit 1 pulses `ev_ack`. Any of bits [4:2] pulses `ev_tmo_ack`.
- R6: A start clears status bits [4:0]. The next 3 status reads return bit 0 = 1 and bit 1 = 0. The following read returns bit 0 = 0 and bit 1 = 1 and pulses `ev_done`.
- R7: The block pointer returns to 0 on a control read and on a start. It advances on each block-data access (offset 7). At 32 it stops, writes there are dropped and reads there return 0xFF.
- R8: A block read returns the byte last written at the pointer if one is held. Otherwise it returns the hardware copy if that is valid, otherwise 0xFF. A start copies written bytes into the hardware copy and discards the written ones. A start with slave address bit 0 = 1 and protocol code 5 (block) invalidates the whole hardware copy.
- R9: An abort during a started transaction sets status bit 4. The next status read returns it without busy and pulses `ev_timeout`.
- R10: Every event output is high only in the cycle of the access that causes it. At most one of done, timeout and acquire is high at a time.
- R11: After reset, all registers read 0x00, the host is idle and no event is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | BUS_AW (8) | Access address, masked to the window |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| ev_start | output | 1 | Start written |
| ev_proto | output | 3 | Protocol code carried with `ev_start` |
| ev_abort | output | 1 | Abort written |
| ev_done | output | 1 | Completion reported to a poll |
| ev_ack | output | 1 | Completion acknowledged |
| ev_timeout | output | 1 | Failure reported to a poll |
| ev_tmo_ack | output | 1 | Failure acknowledged |
| ev_acquire | output | 1 | Semaphore acquired |
| ev_release | output | 1 | Semaphore released |

## Verification
The assertions assume a read strobe and a write strobe are never high in the same cycle. The start, abort and status paths rely on this to exclude each other. The bench drives exactly one strobe per access from a single task, with a one-cycle access each time, so this assumption always holds. The bench walks the host through acquire, release, a full busy countdown, an abort-to-failure path and the block buffer's promote, invalidate and saturate cases. It predicts every read byte and event vector from the requirements.

// File: rtl/smbh_pkg.sv
// Shared constants and types for the SMBus host register emulator.
// Assumes an 8-bit data bus; offsets are compared after window masking.
package smbh_pkg;

    // Register offsets inside the window
    localparam logic [7:0] OFS_STATUS = 8'd0;
    localparam logic [7:0] OFS_CTRL   = 8'd2;
    localparam logic [7:0] OFS_CMD    = 8'd3;
    localparam logic [7:0] OFS_SLAVE  = 8'd4;
    localparam logic [7:0] OFS_DATA0  = 8'd5;
    localparam logic [7:0] OFS_DATA1  = 8'd6;
    localparam logic [7:0] OFS_BLOCK  = 8'd7;
    localparam logic [7:0] OFS_PEC    = 8'd8;
    localparam logic [7:0] OFS_AUXS   = 8'd12;
    localparam logic [7:0] OFS_AUXC   = 8'd13;

    // Bit positions
    localparam int STS_BUSY  = 0;
    localparam int STS_DONE  = 1;
    localparam int STS_KILL  = 4;
    localparam int STS_SEM   = 6;
    localparam int CTL_ABORT = 1;
    localparam int CTL_START = 6;

    localparam logic [2:0] PROTO_BLOCK = 3'd5;

    // Host tracking state
    typedef enum logic [2:0] {
        HS_IDLE,
        HS_ACTIVE,
        HS_STARTED,
        HS_WAIT,
        HS_FAIL
    } host_state_e;

endpackage

// File: rtl/smbh_status_unit.sv
// Status register, semaphore and busy-countdown model.
// Owns the host state and raises the poll/ack events.
// Assumes start/abort requests never coincide with status accesses
// (they come from different offsets of one single-access bus).
module smbh_status_unit
    import smbh_pkg::*;
#(
    parameter int BUSY_POLLS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sts_rd,
    input  logic       sts_wr,
    input  logic       start_req,
    input  logic       abort_req,
    input  logic [7:0] wdata,
    output logic [7:0] sts_view,
    output logic       ev_done,
    output logic       ev_timeout,
    output logic       ev_acquire,
    output logic       ev_release,
    output logic       ev_ack,
    output logic       ev_tmo_ack
);

    localparam int CNT_W = $clog2(BUSY_POLLS + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_POLLS);

    logic [7:0]       sts_q;
    logic [CNT_W-1:0] cnt_q;
    host_state_e      st_q;
    logic             fail_now;

    assign fail_now = |sts_q[4:2];

    // Value presented to a status read in the current state
    always_comb begin
        unique case (st_q)
            HS_IDLE:    sts_view = 8'h00;
            HS_STARTED: begin
                if (fail_now)
                    sts_view = sts_q & ~8'h01;
                else if (cnt_q != '0)
                    sts_view = sts_q | 8'h01;
                else
                    sts_view = (sts_q & ~8'h01) | 8'h02;
            end
            default:    sts_view = sts_q;
        endcase
    end

    // Event pulses aligned with the causing access
    always_comb begin
        ev_acquire = sts_rd && (st_q == HS_IDLE);
        ev_done    = sts_rd && (st_q == HS_STARTED) && !fail_now && (cnt_q == '0);
        ev_timeout = sts_rd && (st_q == HS_STARTED) && fail_now;
        ev_release = sts_wr && wdata[STS_SEM];
        ev_ack     = sts_wr && wdata[STS_DONE];
        ev_tmo_ack = sts_wr && (|wdata[4:2]);
    end

    // Status byte, countdown and host state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= 8'h00;
            cnt_q <= '0;
            st_q  <= HS_IDLE;
        end else if (start_req) begin
            sts_q <= sts_q & 8'hE0;
            cnt_q <= CNT_LOAD;
            st_q  <= HS_STARTED;
        end else if (abort_req) begin
            if (st_q == HS_STARTED) begin
                sts_q[STS_KILL] <= 1'b1;
                cnt_q           <= '0;
            end
        end else if (sts_rd) begin
            sts_q <= sts_view | 8'h40;
            unique case (st_q)
                HS_IDLE: st_q <= HS_ACTIVE;
                HS_STARTED: begin
                    if (fail_now)
                        st_q <= HS_FAIL;
                    else if (cnt_q == '0)
                        st_q <= HS_WAIT;
                    else
                        cnt_q <= cnt_q - 1'b1;
                end
                default: ;
            endcase
        end else if (sts_wr) begin
            sts_q <= sts_q & ~wdata;
            if (wdata[STS_SEM] && st_q != HS_STARTED)
                st_q <= HS_IDLE;
            else if (wdata[STS_DONE] && st_q == HS_WAIT)
                st_q <= HS_ACTIVE;
            else if ((|wdata[4:2]) && st_q == HS_FAIL)
                st_q <= HS_ACTIVE;
        end
    end

    AST_SEM_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        sts_rd |=> sts_q[STS_SEM]); // R4
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sts_wr |=> ((sts_q & $past(wdata)) == 8'h00)); // R5
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LOAD); // R6
    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> (st_q == HS_STARTED && cnt_q == CNT_LOAD)); // R6
    AST_DONE_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |=> (st_q == HS_WAIT)); // R6
    AST_TIMEOUT_TO_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        ev_timeout |=> (st_q == HS_FAIL)); // R9
    AST_POLL_EVENTS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_done, ev_timeout, ev_acquire})); // R10

endmodule

// File: rtl/smbh_block_buf.sv
// Block-data buffer with an auto-advancing, saturating pointer.
// Keeps a "written" copy and a "hardware" copy per byte with valid flags.
// Assumes ptr_clr and promote never coincide with a block access.
module smbh_block_buf #(
    parameter int DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_rd,
    input  logic       acc_wr,
    input  logic       ptr_clr,
    input  logic       promote,
    input  logic       drop_hw,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);

    localparam int PTR_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(DEPTH);

    logic [PTR_W-1:0] ptr_q;
    logic [IDX_W-1:0] idx;
    logic             in_range;
    logic [7:0]       tmp_q [DEPTH];
    logic [7:0]       hw_q  [DEPTH];
    logic [DEPTH-1:0] tmp_v;
    logic [DEPTH-1:0] hw_v;

    assign in_range = (ptr_q < PTR_END);
    assign idx      = ptr_q[IDX_W-1:0];

    // Read priority: written byte, then hardware byte, then 0xFF
    always_comb begin
        if (!in_range)
            rdata = 8'hFF;
        else if (tmp_v[idx])
            rdata = tmp_q[idx];
        else if (hw_v[idx])
            rdata = hw_q[idx];
        else
            rdata = 8'hFF;
    end

    // Pointer: clear, or advance and saturate at DEPTH
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (ptr_clr)
            ptr_q <= '0;
        else if ((acc_rd || acc_wr) && in_range)
            ptr_q <= ptr_q + 1'b1;
    end

    // Storage: promote on start, capture writes otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmp_v <= '0;
            hw_v  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                tmp_q[i] <= 8'h00;
                hw_q[i]  <= 8'h00;
            end
        end else if (promote) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (tmp_v[i])
                    hw_q[i] <= tmp_q[i];
            end
            hw_v  <= drop_hw ? '0 : (hw_v | tmp_v);
            tmp_v <= '0;
        end else if (acc_wr && in_range) begin
            tmp_q[idx] <= wdata;
            tmp_v[idx] <= 1'b1;
        end
    end

    AST_PTR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= PTR_END); // R7
    AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clr |=> (ptr_q == '0)); // R7
    AST_PROMOTE_DROPS_TMP: assert property (@(posedge clk) disable iff (!rst_n)
        promote |=> (tmp_v == '0)); // R8
    AST_HW_INVALIDATED: assert property (@(posedge clk) disable iff (!rst_n)
        (promote && drop_hw) |=> (hw_v == '0)); // R8

endmodule

// File: rtl/smbh_host_emu.sv
// Top of the SMBus host register emulator: address decode, plain
// registers, control handling and read mux. Status behaviour lives in
// smbh_status_unit, block data in smbh_block_buf.
// Assumes at most one of bus_rd / bus_wr per cycle; WIN_BYTES is a power
// of two of at least 16 and at most 256.
module smbh_host_emu
    import smbh_pkg::*;
#(
    parameter int BUS_AW     = 8,
    parameter int WIN_BYTES  = 16,
    parameter int BLK_DEPTH  = 32,
    parameter int BUSY_POLLS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              ev_start,
    output logic [2:0]        ev_proto,
    output logic              ev_abort,
    output logic              ev_done,
    output logic              ev_ack,
    output logic              ev_timeout,
    output logic              ev_tmo_ack,
    output logic              ev_acquire,
    output logic              ev_release
);

    localparam int OFS_W = $clog2(WIN_BYTES);

    logic [7:0] ofs;
    logic hit_sts, hit_ctl, hit_blk;
    logic [7:0] ctrl_q, cmd_q, slave_q, d0_q, d1_q, pec_q, auxs_q, auxc_q;
    logic start_req, abort_req;
    logic [7:0] sts_view, blk_rdata;
    logic [7:0] mux_data;

    // Window masking of the bus address
    assign ofs = 8'(bus_addr[OFS_W-1:0]);

    assign hit_sts = (ofs == OFS_STATUS);
    assign hit_ctl = (ofs == OFS_CTRL);
    assign hit_blk = (ofs == OFS_BLOCK);

    assign start_req = bus_wr && hit_ctl && bus_wdata[CTL_START];
    assign abort_req = bus_wr && hit_ctl && bus_wdata[CTL_ABORT];

    // Plain storage registers and the control byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= 8'h00;
            cmd_q   <= 8'h00;
            slave_q <= 8'h00;
            d0_q    <= 8'h00;
            d1_q    <= 8'h00;
            pec_q   <= 8'h00;
            auxs_q  <= 8'h00;
            auxc_q  <= 8'h00;
        end else if (bus_wr) begin
            unique case (ofs)
                OFS_CTRL:  ctrl_q  <= bus_wdata;
                OFS_CMD:   cmd_q   <= bus_wdata;
                OFS_SLAVE: slave_q <= bus_wdata;
                OFS_DATA0: d0_q    <= bus_wdata;
                OFS_DATA1: d1_q    <= bus_wdata;
                OFS_PEC:   pec_q   <= bus_wdata;
                OFS_AUXS:  auxs_q  <= bus_wdata;
                OFS_AUXC:  auxc_q  <= bus_wdata;
                default: ;
            endcase
        end
    end

    smbh_status_unit #(
        .BUSY_POLLS (BUSY_POLLS)
    ) status_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sts_rd     (bus_rd && hit_sts),
        .sts_wr     (bus_wr && hit_sts),
        .start_req  (start_req),
        .abort_req  (abort_req),
        .wdata      (bus_wdata),
        .sts_view   (sts_view),
        .ev_done    (ev_done),
        .ev_timeout (ev_timeout),
        .ev_acquire (ev_acquire),
        .ev_release (ev_release),
        .ev_ack     (ev_ack),
        .ev_tmo_ack (ev_tmo_ack)
    );

    smbh_block_buf #(
        .DEPTH (BLK_DEPTH)
    ) block_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_rd  (bus_rd && hit_blk),
        .acc_wr  (bus_wr && hit_blk),
        .ptr_clr ((bus_rd && hit_ctl) || start_req),
        .promote (start_req),
        .drop_hw (start_req && slave_q[0] && (bus_wdata[4:2] == PROTO_BLOCK)),
        .wdata   (bus_wdata),
        .rdata   (blk_rdata)
    );

    // Read data selection by offset
    always_comb begin
        unique case (ofs)
            OFS_STATUS: mux_data = sts_view;
            OFS_CTRL:   mux_data = ctrl_q & ~8'h40;
            OFS_CMD:    mux_data = cmd_q;
            OFS_SLAVE:  mux_data = slave_q;
            OFS_DATA0:  mux_data = d0_q;
            OFS_DATA1:  mux_data = d1_q;
            OFS_BLOCK:  mux_data = blk_rdata;
            OFS_PEC:    mux_data = pec_q;
            OFS_AUXS:   mux_data = auxs_q;
            OFS_AUXC:   mux_data = auxc_q;
            default:    mux_data = 8'h00;
        endcase
    end

    // Drive read data only during a read access
    assign bus_rdata = bus_rd ? mux_data : 8'h00;

    // Control-write events
    assign ev_start = start_req;
    assign ev_abort = abort_req;
    assign ev_proto = start_req ? bus_wdata[4:2] : 3'd0;

    AST_NO_RDWR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr)); // R10
    AST_CMD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && ofs == OFS_CMD) |=> $stable(cmd_q)); // R1
    AST_CTRL_WRITE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_ctl) |=> (ctrl_q == $past(bus_wdata))); // R2

endmodule

// File: tb/smbh_host_emu_tb_top.sv
// Scoreboard bench: access tasks push expected read data and events,
// a negedge monitor pops and compares them against the outputs.
module smbh_host_emu_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ev_start, ev_abort, ev_done, ev_ack;
    logic       ev_timeout, ev_tmo_ack, ev_acquire, ev_release;
    logic [2:0] ev_proto;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // Expected-event encoding: [10:8] proto, 7 start, 6 abort, 5 done,
    // 4 ack, 3 timeout, 2 tmo_ack, 1 acquire, 0 release
    localparam logic [10:0] E_NONE = 11'h000;
    localparam logic [10:0] E_STRT = 11'h080;
    localparam logic [10:0] E_ABRT = 11'h040;
    localparam logic [10:0] E_DONE = 11'h020;
    localparam logic [10:0] E_ACK  = 11'h010;
    localparam logic [10:0] E_TMO  = 11'h008;
    localparam logic [10:0] E_TACK = 11'h004;
    localparam logic [10:0] E_ACQ  = 11'h002;
    localparam logic [10:0] E_REL  = 11'h001;

    logic        q_is_rd [$];
    logic [7:0]  q_data  [$];
    logic [10:0] q_ev    [$];
    string       q_tag   [$];

    always #5 clk = ~clk;

    smbh_host_emu dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ev_start   (ev_start),
        .ev_proto   (ev_proto),
        .ev_abort   (ev_abort),
        .ev_done    (ev_done),
        .ev_ack     (ev_ack),
        .ev_timeout (ev_timeout),
        .ev_tmo_ack (ev_tmo_ack),
        .ev_acquire (ev_acquire),
        .ev_release (ev_release)
    );

    function automatic logic [10:0] ev_now();
        return {ev_proto, ev_start, ev_abort, ev_done, ev_ack,
                ev_timeout, ev_tmo_ack, ev_acquire, ev_release};
    endfunction

    // Driver: one read access with expected data and events
    task automatic rd(input logic [7:0] a, input logic [7:0] exp,
                      input logic [10:0] ev, input string tag);
        bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
        q_is_rd.push_back(1'b1); q_data.push_back(exp);
        q_ev.push_back(ev); q_tag.push_back(tag);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    // Driver: one write access with expected events
    task automatic wr(input logic [7:0] a, input logic [7:0] d,
                      input logic [10:0] ev, input string tag);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        q_is_rd.push_back(1'b0); q_data.push_back(8'h00);
        q_ev.push_back(ev); q_tag.push_back(tag);
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    // Monitor: compare each access, and check quiet cycles carry no events
    always @(negedge clk) begin
        if (!rst_n) begin
            n_checks++;
            if (ev_now() != E_NONE) begin
                n_fail++;
                $display("FAIL R11 events in reset: actual %h expected %h", ev_now(), E_NONE);
            end
        end else if (bus_rd || bus_wr) begin
            if (q_tag.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R10 unexpected access: actual access expected none");
            end else begin
                automatic logic        is_rd = q_is_rd.pop_front();
                automatic logic [7:0]  d     = q_data.pop_front();
                automatic logic [10:0] e     = q_ev.pop_front();
                automatic string       t     = q_tag.pop_front();
                if (is_rd) begin
                    n_checks++;
                    if (bus_rdata !== d) begin
                        n_fail++;
                        $display("FAIL %s data: actual %h expected %h", t, bus_rdata, d);
                    end
                end
                n_checks++;
                if (ev_now() !== e) begin
                    n_fail++;
                    $display("FAIL %s events: actual %h expected %h", t, ev_now(), e);
                end
            end
        end else begin
            n_checks++;
            if (ev_now() !== E_NONE) begin
                n_fail++;
                $display("FAIL R10 event without access: actual %h expected %h", ev_now(), E_NONE);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Stimulus
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11 reset state
        rd(8'd2,  8'h00, E_NONE, "R11 ctrl");
        rd(8'd3,  8'h00, E_NONE, "R11 cmd");
        rd(8'd13, 8'h00, E_NONE, "R11 auxc");
        rd(8'd7,  8'hFF, E_NONE, "R11 block empty");

        // R1 plain storage, masking, unmapped offsets
        wr(8'd3,  8'hA5, E_NONE, "R1 cmd");
        wr(8'd4,  8'h5B, E_NONE, "R1 slave");
        wr(8'd5,  8'h11, E_NONE, "R1 data0");
        wr(8'd6,  8'h22, E_NONE, "R1 data1");
        wr(8'd8,  8'h33, E_NONE, "R1 pec");
        wr(8'd12, 8'h44, E_NONE, "R1 auxs");
        wr(8'd13, 8'h55, E_NONE, "R1 auxc");
        rd(8'd3,  8'hA5, E_NONE, "R1 cmd");
        rd(8'd4,  8'h5B, E_NONE, "R1 slave");
        rd(8'd5,  8'h11, E_NONE, "R1 data0");
        rd(8'd6,  8'h22, E_NONE, "R1 data1");
        rd(8'd8,  8'h33, E_NONE, "R1 pec");
        rd(8'd12, 8'h44, E_NONE, "R1 auxs");
        rd(8'd13, 8'h55, E_NONE, "R1 auxc");
        wr(8'h13, 8'h77, E_NONE, "R1 masked write");
        rd(8'd3,  8'h77, E_NONE, "R1 masked readback");
        wr(8'd1,  8'h99, E_NONE, "R1 unmapped write");
        rd(8'd1,  8'h00, E_NONE, "R1 unmapped read");
        rd(8'd9,  8'h00, E_NONE, "R1 unmapped read 9");

        // R3 / R4 acquire and semaphore
        rd(8'd0, 8'h00, E_ACQ,  "R3 idle status read");
        rd(8'd0, 8'h40, E_NONE, "R4 semaphore set");

        // R5 release
        wr(8'd0, 8'h40, E_REL,  "R5 release");
        rd(8'd0, 8'h00, E_ACQ,  "R5 back to idle");

        // R2 start and control read
        wr(8'd2, 8'h48, E_STRT | 11'h200, "R2 start byte-data");
        rd(8'd2, 8'h08, E_NONE, "R2 ctrl read start cleared");

        // R6 busy countdown and done
        rd(8'd0, 8'h41, E_NONE, "R6 busy poll 1");
        rd(8'd0, 8'h41, E_NONE, "R6 busy poll 2");
        rd(8'd0, 8'h41, E_NONE, "R6 busy poll 3");
        rd(8'd0, 8'h42, E_DONE, "R6 done poll");
        rd(8'd0, 8'h42, E_NONE, "R6 done held");
        wr(8'd0, 8'h02, E_ACK,  "R5 ack done");
        rd(8'd0, 8'h40, E_NONE, "R5 done cleared");

        // R9 abort while started
        wr(8'd2, 8'h40, E_STRT, "R9 start quick");
        wr(8'd2, 8'h02, E_ABRT, "R2 abort");
        rd(8'd0, 8'h50, E_TMO,  "R9 failure reported");
        wr(8'd0, 8'h10, E_TACK, "R5 failure ack");
        rd(8'd0, 8'h40, E_NONE, "R9 failure cleared");

        // R7 / R8 block buffer
        rd(8'd2, 8'h02, E_NONE, "R7 ctrl read clears ptr");
        wr(8'd7, 8'hB0, E_NONE, "R8 blk wr0");
        wr(8'd7, 8'hB1, E_NONE, "R8 blk wr1");
        wr(8'd7, 8'hB2, E_NONE, "R8 blk wr2");
        wr(8'd7, 8'hB3, E_NONE, "R8 blk wr3");
        rd(8'd2, 8'h02, E_NONE, "R7 ctrl read");
        rd(8'd7, 8'hB0, E_NONE, "R8 written byte 0");
        rd(8'd7, 8'hB1, E_NONE, "R8 written byte 1");
        rd(8'd7, 8'hB2, E_NONE, "R8 written byte 2");
        rd(8'd7, 8'hB3, E_NONE, "R8 written byte 3");
        rd(8'd7, 8'hFF, E_NONE, "R8 empty slot");
        wr(8'd4, 8'h5A, E_NONE, "R8 slave write dir");
        wr(8'd2, 8'h54, E_STRT | 11'h500, "R8 start block write");
        rd(8'd7, 8'hB0, E_NONE, "R8 hw copy 0");
        rd(8'd7, 8'hB1, E_NONE, "R8 hw copy 1");
        wr(8'd7, 8'hC2, E_NONE, "R8 overwrite slot 2");
        rd(8'd2, 8'h14, E_NONE, "R7 ctrl read");
        rd(8'd7, 8'hB0, E_NONE, "R8 hw 0");
        rd(8'd7, 8'hB1, E_NONE, "R8 hw 1");
        rd(8'd7, 8'hC2, E_NONE, "R8 written over hw 2");
        rd(8'd7, 8'hB3, E_NONE, "R8 hw 3");
        wr(8'd4, 8'h5B, E_NONE, "R8 slave read dir");
        wr(8'd2, 8'h54, E_STRT | 11'h500, "R8 start block read");
        rd(8'd2, 8'h14, E_NONE, "R7 ctrl read");
        rd(8'd7, 8'hFF, E_NONE, "R8 hw invalidated 0");
        rd(8'd7, 8'hFF, E_NONE, "R8 hw invalidated 1");

        // R7 saturation
        rd(8'd2, 8'h14, E_NONE, "R7 ctrl read");
        for (int i = 0; i < 32; i++)
            wr(8'd7, 8'(8'h20 + i), E_NONE, "R7 fill");
        wr(8'd7, 8'hEE, E_NONE, "R7 write past end");
        rd(8'd2, 8'h14, E_NONE, "R7 ctrl read");
        for (int i = 0; i < 32; i++)
            rd(8'd7, 8'(8'h20 + i), E_NONE, "R7 readback");
        rd(8'd7, 8'hFF, E_NONE, "R7 read past end");
        rd(8'd7, 8'hFF, E_NONE, "R7 still past end");

        repeat (3) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            if (q_tag.size() != 0) begin
                n_checks++; n_fail++;
                $display("FAIL R10 pending items: actual %0d expected 0", q_tag.size());
            end
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule